// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Shared Tag Store

This block fronts a backing RAM with a small direct-mapped, read-only cache. The requester holds an address on `addr_i` and the controller keeps serving it: each lookup captures the address, checks the cache, and reports one result. The next lookup starts at once, so an address that is held steady is read again and again with no request strobe.

Tags and data share one cache memory of twice the line count. The lower half holds each line's data word. The upper half, at the same line index, holds a valid bit and the full address that was cached there. A single access pointer moves between the two halves during a lookup: tag read, compare, then either data read or RAM read followed by fill. The compare subtracts the stored address from the requested one and tests the result for zero. On a miss the RAM word is returned and written into the line together with its address.

The RAM read port runs on every cycle at the latched request address. The hit flag chooses whether the cache word or the RAM word drives `rdata_o`.

Top module: `shared_tag_cache`

## Requirements
- R1: While reset is asserted, `valid_o` and `hit_o` are 0. After reset every line is invalid, so the first lookup of any address misses (`hit_o`=0). This holds for address 0 too.
- R2: `valid_o` is a one-cycle pulse, one per lookup. Counted from the last cycle of the previous pulse, a hit reports 3 cycles later and a miss reports 4 cycles later.
- R3: On a miss, `rdata_o` equals the RAM word at the requested address and `hit_o` is 0. The cache is written in the two cycles that end the lookup: the data half first, then the tag half.
- R4: After a miss has filled a line, the same address hits and returns the filled word, even if the RAM content has changed since the fill.
- R5: The line index is address bits [3:0]. A miss on an address with the same index and different upper bits replaces the line, so the earlier address misses again.
- R6: Lookups to one line leave every other line unchanged.
- R7: The address is captured in the first cycle of a lookup. A change on `addr_i` after that does not affect the lookup in progress. The new address is served by the following lookup.
- R8: A hit never writes the cache. Repeated hits keep returning the stored word while the RAM content changes.
- R9: `ram_addr_o` carries the captured request address for the whole lookup. It equals that address when `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Requested address, held continuously |
| rdata_o | output | 8 | Returned word, meaningful while `valid_o` is high |
| hit_o | output | 1 | Result of the last compare; 1 means the word came from the cache |
| valid_o | output | 1 | One-cycle strobe marking a completed lookup |
| ram_addr_o | output | 8 | Backing RAM read address |
| ram_rdata_i | input | 8 | Backing RAM read data, one cycle after the address |

## Verification
The assertions assume the backing RAM has a single-cycle synchronous read latency. They also assume the RAM's output for an unchanged address does not change during the last two cycles of a miss. The bench RAM is a registered function of the address and a generation counter. The bench changes that counter only right after a result strobe, when the next lookup has not yet reached its RAM read. Requester addresses change only at falling edges. Some changes are placed on purpose just after the capture cycle.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [2:0] {
    ST_TAG  = 3'd0,
    ST_CMP  = 3'd1,
    ST_DATA = 3'd2,
    ST_RAM  = 3'd3,
    ST_FILL = 3'd4
  } lk_state_e;
endpackage

// File: rtl/stc_store.sv
// Shared tag/data memory: half_i=1 selects the tag half.
module stc_store #(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 2 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [IDX_W:0]    ptr;

  assign ptr = {half_i, idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= mem_q[ptr];  // read-first
      if (we_i) mem_q[ptr] <= wdata_i;
    end
  end
endmodule

// File: rtl/stc_zero_cmp.sv
// Subtract-and-zero-flag address compare.
module stc_zero_cmp #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              zf_o
);
  logic [ADDR_W-1:0] diff;
  assign diff = a_i - b_i;
  assign zf_o = (diff == '0);
endmodule

// File: rtl/stc_fsm.sv
module stc_fsm
  import stc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      zf_i,
  input  logic      tag_vld_i,
  output lk_state_e state_o,
  output logic      hit_o
);
  lk_state_e state_d;

  always_comb begin
    unique case (state_o)
      ST_TAG:  state_d = ST_CMP;
      ST_CMP:  state_d = (zf_i && tag_vld_i) ? ST_DATA : ST_RAM;
      ST_DATA: state_d = ST_TAG;
      ST_RAM:  state_d = ST_FILL;
      ST_FILL: state_d = ST_TAG;
      default: state_d = ST_TAG;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_TAG;
      hit_o   <= 1'b0;
    end else begin
      state_o <= state_d;
      if (state_o == ST_CMP) hit_o <= zf_i && tag_vld_i;
    end
  end
endmodule

// File: rtl/shared_tag_cache.sv
module shared_tag_cache
  import stc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hit_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  localparam int TAG_W  = ADDR_W + 1;
  localparam int WORD_W = (DATA_W > TAG_W) ? DATA_W : TAG_W;

  lk_state_e         state;
  logic [ADDR_W-1:0] req_q;
  logic [IDX_W-1:0]  idx;
  logic              half;
  logic              mem_we;
  logic [WORD_W-1:0] mem_wdata;
  logic [WORD_W-1:0] mem_rdata;
  logic              zf;
  logic              hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              req_q <= '0;
    else if (state == ST_TAG) req_q <= addr_i;
  end

  // Pointer: tag half for tag read and tag fill, data half otherwise.
  assign half   = (state == ST_TAG) || (state == ST_FILL);
  assign idx    = (state == ST_TAG) ? addr_i[IDX_W-1:0] : req_q[IDX_W-1:0];
  assign mem_we = (state == ST_RAM) || (state == ST_FILL);

  always_comb begin
    if (state == ST_FILL) mem_wdata = WORD_W'({1'b1, req_q});
    else                  mem_wdata = WORD_W'(ram_rdata_i);
  end

  stc_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .half_i  (half),
    .idx_i   (idx),
    .we_i    (mem_we),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  stc_zero_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .a_i  (req_q),
    .b_i  (mem_rdata[ADDR_W-1:0]),
    .zf_o (zf)
  );

  stc_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zf_i      (zf),
    .tag_vld_i (mem_rdata[ADDR_W]),
    .state_o   (state),
    .hit_o     (hit_q)
  );

  assign ram_addr_o = req_q;
  assign valid_o    = (state == ST_DATA) || (state == ST_FILL);
  assign hit_o      = hit_q;
  assign rdata_o    = hit_q ? mem_rdata[DATA_W-1:0] : ram_rdata_i;
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              hit_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] ram_addr_i
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_i && !hit_i);

  p_valid_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i ##1 !valid_i);

  p_miss_fills_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !hit_i |-> we_i && $past(we_i));

  p_no_write_on_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && hit_i |-> !we_i);

  p_ram_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $stable(ram_addr_i));
endmodule

bind shared_tag_cache stc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_o),
  .hit_i      (hit_o),
  .we_i       (mem_we),
  .ram_addr_i (ram_addr_o)
);

// File: tb/tb_shared_tag_cache.sv
module tb_shared_tag_cache;
  timeunit 1ns; timeprecision 1ps;

  localparam int LINES = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] rdata_o, ram_addr_o;
  logic [7:0] ram_rdata = '0;
  logic       hit_o, valid_o;

  int checks = 0;
  int fails  = 0;
  int gen    = 0;

  logic       m_v   [LINES];
  logic [7:0] m_tag [LINES];
  logic [7:0] m_dat [LINES];

  always #5 clk = ~clk;

  function automatic logic [7:0] ram_word(logic [7:0] a, int g);
    return a * 8'd29 + 8'(g) * 8'd71 + 8'd5;
  endfunction

  always_ff @(posedge clk) ram_rdata <= ram_word(ram_addr_o, gen);

  shared_tag_cache dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .rdata_o     (rdata_o),
    .hit_o       (hit_o),
    .valid_o     (valid_o),
    .ram_addr_o  (ram_addr_o),
    .ram_rdata_i (ram_rdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Runs one lookup from a falling edge; optionally swaps addr after capture.
  task automatic lookup(logic [7:0] a, bit swap, logic [7:0] b, bit lat, string req);
    int         cyc;
    logic [3:0] idx;
    bit         exp_hit;
    logic [7:0] exp_dat;
    addr_i = a;
    cyc = 0;
    if (swap) begin
      @(negedge clk); @(negedge clk);
      cyc = 2;
      addr_i = b;
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (valid_o || cyc > 20) break;
    end
    if (!valid_o) begin
      chk(req, "timeout", 32'(valid_o), 32'd1);
      return;
    end
    idx     = a[3:0];
    exp_hit = m_v[idx] && (m_tag[idx] == a);
    exp_dat = exp_hit ? m_dat[idx] : ram_word(a, gen);
    if (!exp_hit) begin
      m_v[idx]   = 1'b1;
      m_tag[idx] = a;
      m_dat[idx] = exp_dat;
    end
    chk(req, "hit", 32'(hit_o), 32'(exp_hit));
    chk(req, "data", 32'(rdata_o), 32'(exp_dat));
    chk("R9", "ram_addr", 32'(ram_addr_o), 32'(a));
    if (lat) chk("R2", "latency", 32'(cyc), exp_hit ? 32'd3 : 32'd4);
  endtask

  initial begin
    #3ms;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_dat[i] = '0;
    end
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(valid_o), 32'd0);
    chk("R1", "hit in reset", 32'(hit_o), 32'd0);
    rst_ni = 1'b1;

    // R1: address 0 misses despite zeroed tag memory
    lookup(8'h00, 1'b0, 8'h00, 1'b0, "R1");
    chk("R1", "addr0 first miss", 32'(hit_o), 32'd0);
    // R4: refill served from cache
    lookup(8'h00, 1'b0, 8'h00, 1'b1, "R4");
    chk("R4", "refetch hit", 32'(hit_o), 32'd1);
    // R8: RAM changes, hits keep old word
    gen++;
    lookup(8'h00, 1'b0, 8'h00, 1'b1, "R8");
    lookup(8'h00, 1'b0, 8'h00, 1'b1, "R8");
    chk("R8", "stale word kept", 32'(rdata_o), 32'(ram_word(8'h00, 0)));
    // R5: same index, different upper bits evicts
    lookup(8'h13, 1'b0, 8'h00, 1'b1, "R5");
    lookup(8'h23, 1'b0, 8'h00, 1'b1, "R5");
    lookup(8'h13, 1'b0, 8'h00, 1'b1, "R5");
    chk("R5", "evicted miss", 32'(hit_o), 32'd0);
    // R6: neighbouring lines independent
    lookup(8'h05, 1'b0, 8'h00, 1'b1, "R6");
    lookup(8'h06, 1'b0, 8'h00, 1'b1, "R6");
    lookup(8'h05, 1'b0, 8'h00, 1'b1, "R6");
    chk("R6", "neighbour kept", 32'(hit_o), 32'd1);
    // R7: change after capture serves old address first
    lookup(8'h41, 1'b1, 8'h42, 1'b1, "R7");
    lookup(8'h42, 1'b0, 8'h00, 1'b1, "R7");
    lookup(8'h41, 1'b1, 8'h05, 1'b1, "R7");
    lookup(8'h05, 1'b0, 8'h00, 1'b1, "R7");

    // R3: random mix of hits and misses
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a, b;
      bit         sw;
      a  = 8'($urandom_range(0, 47));
      b  = 8'($urandom_range(0, 47));
      sw = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) gen++;
      lookup(a, sw, b, 1'b1, "R3");
    end

    summary();
    $finish;
  end
endmodule